// File: doc/BRIEF.md
# Bit-Serial Compare-Exchange Node

This block is a two-input, two-output sorting element for bit-serial sorting networks. Two unsigned words enter one digit per cycle, most significant digit first, on `in_a` and `in_b`. While the digits seen so far match, the node passes each input straight to its output (bypass). On the first valid cycle where the digits differ, the node works out which word is larger. It then locks either the bypass route or the crossed route (exchange), so that the output chosen by the direction input carries the larger word from that digit to the end of the word.

The deciding digit is already routed correctly in the cycle it arrives, because the choice is made combinationally and the registered route only takes over from the next cycle. The locked route stays in force until a one-cycle synchronous `rst` pulse between words frees the node. The digit width is a parameter (default one bit). A second parameter can tie the sort direction to a fixed value.

Top module: `serial_cmpx_node`

## Requirements
- R1: `out_vld` equals `in_vld` in the same cycle. While `in_vld` is 0, both `out0` and `out1` are 0.
- R2: While the node is undecided and the two current valid digits are equal, it stays undecided and routes straight: `out0` = `in_a` and `out1` = `in_b`.
- R3: On the first valid cycle with unequal digits (unsigned compare), the larger digit appears in that same cycle on `out0` when `dir` = 0, or on `out1` when `dir` = 1.
- R4: Once decided, the route holds for every later digit of the word. For each word, the output selected by `dir` reproduces the larger word and the other output reproduces the smaller word.
- R5: `dir` is sampled only while the node is undecided. Changing it after the decision does not change the routing.
- R6: If the two words are equal in every digit, the node routes straight for the whole word.
- R7: A one-cycle `rst` pulse clears the decision, so the next word pair is judged afresh. After reset, with `in_vld` at 0, the outputs read `out_vld` = 0 and `out0` = `out1` = 0.
- R8: Digits presented with `in_vld` at 0 take no part in the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; a one-cycle pulse frees the node between words |
| in_vld | input | 1 | Qualifies the current input digits |
| dir | input | 1 | 0: larger word to `out0`; 1: larger word to `out1` |
| in_a | input | DIGIT_W | Serial word A, most significant digit first |
| in_b | input | DIGIT_W | Serial word B, most significant digit first |
| out_vld | output | 1 | Valid for `out0`/`out1`, same cycle as `in_vld` |
| out0 | output | DIGIT_W | Routed output 0 |
| out1 | output | DIGIT_W | Routed output 1 |

## Verification
A decision latched on the wrong digit, or with the wrong polarity, shows up at the ports at the first digit after the deciding one: from then on, one output carries a mix of the two words instead of a clean maximum. A route that fails to hold, or a reset that fails to clear it, corrupts the next word within one cycle of the change. Pairs that differ only in the last digit expose an early lock, because a premature decision can only show in that final cycle. Collecting each serial output into a whole word and comparing it with the maximum or minimum catches all of these faults.

// File: rtl/cmpx_pkg.sv
package cmpx_pkg;

  typedef enum logic {
    ROUTE_STRAIGHT = 1'b0,
    ROUTE_CROSSED  = 1'b1
  } route_e;

endpackage

// File: rtl/cmpx_digit_cmp.sv
module cmpx_digit_cmp #(
  parameter int DIGIT_W = 1
) (
  input  logic [DIGIT_W-1:0] dig_a,
  input  logic [DIGIT_W-1:0] dig_b,
  output logic               differ,
  output logic               a_larger
);

  generate
    if (DIGIT_W == 1) begin : g_bit
      assign differ   = dig_a[0] ^ dig_b[0];
      assign a_larger = dig_a[0] & ~dig_b[0];
    end else begin : g_digit
      assign differ   = (dig_a != dig_b);
      assign a_larger = (dig_a > dig_b);
    end
  endgenerate

endmodule

// File: rtl/cmpx_route_ctl.sv
module cmpx_route_ctl
  import cmpx_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   in_vld,
  input  logic   differ,
  input  logic   a_larger,
  input  logic   dir_eff,
  output route_e route_now,
  output logic   locked
);

  logic   locked_q;
  route_e route_q;
  logic   want_cross;
  logic   take_now;

  // dir 0 keeps the larger word on out0: cross only when B is larger.
  assign want_cross = dir_eff ? a_larger : ~a_larger;
  assign take_now   = in_vld & ~locked_q & differ;

  always_comb begin
    if (locked_q) begin
      route_now = route_q;
    end else if (take_now && want_cross) begin
      route_now = ROUTE_CROSSED;
    end else begin
      route_now = ROUTE_STRAIGHT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b0;
      route_q  <= ROUTE_STRAIGHT;
    end else if (take_now) begin
      locked_q <= 1'b1;
      route_q  <= want_cross ? ROUTE_CROSSED : ROUTE_STRAIGHT;
    end
  end

  assign locked = locked_q;

endmodule

// File: rtl/cmpx_xbar.sv
module cmpx_xbar
  import cmpx_pkg::*;
#(
  parameter int DIGIT_W = 1
) (
  input  logic               in_vld,
  input  route_e             route,
  input  logic [DIGIT_W-1:0] in_a,
  input  logic [DIGIT_W-1:0] in_b,
  output logic [DIGIT_W-1:0] out0,
  output logic [DIGIT_W-1:0] out1
);

  always_comb begin
    out0 = '0;
    out1 = '0;
    if (in_vld) begin
      if (route == ROUTE_CROSSED) begin
        out0 = in_b;
        out1 = in_a;
      end else begin
        out0 = in_a;
        out1 = in_b;
      end
    end
  end

endmodule

// File: rtl/serial_cmpx_node.sv
module serial_cmpx_node
  import cmpx_pkg::*;
#(
  parameter int DIGIT_W   = 1,
  parameter bit DIR_EN    = 1'b1,
  parameter bit FIXED_DIR = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_vld,
  input  logic               dir,
  input  logic [DIGIT_W-1:0] in_a,
  input  logic [DIGIT_W-1:0] in_b,
  output logic               out_vld,
  output logic [DIGIT_W-1:0] out0,
  output logic [DIGIT_W-1:0] out1
);

  logic   differ;
  logic   a_larger;
  logic   dir_eff;
  logic   locked;
  route_e route_now;

  generate
    if (DIR_EN) begin : g_dir_port
      assign dir_eff = dir;
    end else begin : g_dir_fixed
      assign dir_eff = FIXED_DIR;
    end
  endgenerate

  cmpx_digit_cmp #(.DIGIT_W(DIGIT_W)) u_cmp (
    .dig_a    (in_a),
    .dig_b    (in_b),
    .differ   (differ),
    .a_larger (a_larger)
  );

  cmpx_route_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .differ    (differ),
    .a_larger  (a_larger),
    .dir_eff   (dir_eff),
    .route_now (route_now),
    .locked    (locked)
  );

  cmpx_xbar #(.DIGIT_W(DIGIT_W)) u_xbar (
    .in_vld (in_vld),
    .route  (route_now),
    .in_a   (in_a),
    .in_b   (in_b),
    .out0   (out0),
    .out1   (out1)
  );

  assign out_vld = in_vld;

endmodule

// File: rtl/cmpx_node_chk.sv
module cmpx_node_chk #(
  parameter int DIGIT_W   = 1,
  parameter bit DIR_EN    = 1'b1,
  parameter bit FIXED_DIR = 1'b0
) (
  input logic               clk,
  input logic               rst,
  input logic               in_vld,
  input logic               dir,
  input logic [DIGIT_W-1:0] in_a,
  input logic [DIGIT_W-1:0] in_b,
  input logic [DIGIT_W-1:0] out0,
  input logic [DIGIT_W-1:0] out1,
  input logic               locked
);

  logic d_eff;
  assign d_eff = DIR_EN ? dir : FIXED_DIR;

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |-> (out0 == '0 && out1 == '0));

  // R4
  permute_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |-> ((out0 == in_a && out1 == in_b) || (out0 == in_b && out1 == in_a)));

  // R3
  first_diff_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !locked && in_a != in_b) |-> (d_eff ? (out1 > out0) : (out0 > out1)));

  // R2
  equal_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !locked && in_a == in_b) |=> !locked);

  // R4
  hold_lock_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  // R7
  reset_free_chk: assert property (@(posedge clk)
    rst |=> !locked);

  // R8
  idle_no_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_vld && !locked) |=> !locked);

endmodule

bind serial_cmpx_node cmpx_node_chk #(
  .DIGIT_W   (DIGIT_W),
  .DIR_EN    (DIR_EN),
  .FIXED_DIR (FIXED_DIR)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .in_vld (in_vld),
  .dir    (dir),
  .in_a   (in_a),
  .in_b   (in_b),
  .out0   (out0),
  .out1   (out1),
  .locked (locked)
);

// File: tb/test_serial_cmpx_node.sv
module test_serial_cmpx_node;

  localparam int WW = 8;
  localparam int NV = 12;
  // {dir, a, b}
  localparam logic [2*WW:0] VEC [NV] = '{
    {1'b0, 8'h5A, 8'h3C}, {1'b0, 8'h3C, 8'h5A},
    {1'b1, 8'h5A, 8'h3C}, {1'b1, 8'h3C, 8'h5A},
    {1'b0, 8'h77, 8'h77}, {1'b1, 8'h00, 8'h00},
    {1'b0, 8'hA4, 8'hA5}, {1'b1, 8'hA4, 8'hA5},
    {1'b0, 8'hFF, 8'h00}, {1'b1, 8'h80, 8'h7F},
    {1'b0, 8'h01, 8'h00}, {1'b1, 8'hFE, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic dir = 1'b0;
  logic in_a = 1'b0;
  logic in_b = 1'b0;
  logic out_vld;
  logic out0;
  logic out1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_cmpx_node i_serial_cmpx_node (
    .clk(clk), .rst(rst), .in_vld(in_vld), .dir(dir),
    .in_a(in_a), .in_b(in_b), .out_vld(out_vld), .out0(out0), .out1(out1)
  );

  task automatic chk(input bit ok, input string req, input logic [WW-1:0] act,
                     input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_rst();
    @(negedge clk);
    in_vld = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // flip: digits with index below flip see the inverted dir (R5 test)
  task automatic send_word(input logic [WW-1:0] a, input logic [WW-1:0] b,
                           input logic d, input int flip,
                           output logic [WW-1:0] g0, output logic [WW-1:0] g1,
                           output bit vld_ok);
    vld_ok = 1'b1;
    for (int i = WW - 1; i >= 0; i--) begin
      @(negedge clk);
      in_vld = 1'b1;
      in_a = a[i];
      in_b = b[i];
      dir = (i < flip) ? ~d : d;
      #1;
      g0[i] = out0;
      g1[i] = out1;
      if (out_vld !== 1'b1) vld_ok = 1'b0;
    end
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic run_pair(input logic [WW-1:0] a, input logic [WW-1:0] b,
                          input logic d, input string req);
    logic [WW-1:0] g0, g1, mx, mn;
    bit vok;
    mx = (a > b) ? a : b;
    mn = (a > b) ? b : a;
    pulse_rst();
    send_word(a, b, d, -1, g0, g1, vok);
    chk(vok, "R1 out_vld", {7'd0, vok}, 8'd1);
    chk((d ? g1 : g0) == mx, {req, " max side"}, d ? g1 : g0, mx);
    chk((d ? g0 : g1) == mn, {req, " min side"}, d ? g0 : g1, mn);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 8'd0, 8'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [WW-1:0] g0, g1, ra, rb;
    logic [15:0] lfsr;
    bit vok;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R7 reset state
    chk(out_vld == 1'b0 && out0 == 1'b0 && out1 == 1'b0, "R7 reset outputs",
        {5'd0, out_vld, out0, out1}, 8'd0);

    // table walk: R3 R4 R6
    for (int v = 0; v < NV; v++) begin
      run_pair(VEC[v][2*WW-1:WW], VEC[v][WW-1:0], VEC[v][2*WW], "R4 table");
    end

    // random pairs, some equal (R6), some differing only in LSB (R3)
    for (int n = 0; n < 40; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ra = lfsr[7:0];
      rb = lfsr[15:8];
      if (n % 5 == 0) rb = ra;
      if (n % 7 == 0) rb = ra ^ 8'h01;
      run_pair(ra, rb, n[0], "R4 random");
    end

    // R6: equal words go straight, checked per output
    pulse_rst();
    send_word(8'hC3, 8'hC3, 1'b1, -1, g0, g1, vok);
    chk(g0 == 8'hC3 && g1 == 8'hC3, "R6 equal straight", g0, 8'hC3);

    // R2 + R3: first differing digit routed in its own cycle (dir=1, A larger at bit 4)
    pulse_rst();
    send_word(8'hB0, 8'hA0, 1'b1, -1, g0, g1, vok);
    chk(g1 == 8'hB0, "R3 deciding digit on out1", g1, 8'hB0);
    chk(g0 == 8'hA0, "R2 prefix then min on out0", g0, 8'hA0);

    // R5: dir flips after the MSB decision; routing must not change
    pulse_rst();
    send_word(8'h80, 8'h7F, 1'b0, 7, g0, g1, vok);
    chk(g0 == 8'h80, "R5 dir ignored after lock out0", g0, 8'h80);
    chk(g1 == 8'h7F, "R5 dir ignored after lock out1", g1, 8'h7F);

    // R8: differing digits with in_vld low must not lock the node
    pulse_rst();
    @(negedge clk);
    in_vld = 1'b0;
    in_a = 1'b1;
    in_b = 1'b0;
    dir = 1'b0;
    #1;
    chk(out0 == 1'b0 && out1 == 1'b0, "R1 idle outputs zero", {6'd0, out0, out1}, 8'd0);
    send_word(8'h0F, 8'hF0, 1'b0, -1, g0, g1, vok);
    chk(g0 == 8'hF0, "R8 invalid digit ignored", g0, 8'hF0);

    // R7: reset mid-word frees the node
    pulse_rst();
    @(negedge clk);
    in_vld = 1'b1;
    in_a = 1'b1;
    in_b = 1'b0;
    dir = 1'b0;
    pulse_rst();
    send_word(8'h01, 8'h02, 1'b0, -1, g0, g1, vok);
    chk(g0 == 8'h02, "R7 fresh decision after reset", g0, 8'h02);
    #1;
    chk(out_vld == 1'b0, "R1 out_vld low between words", {7'd0, out_vld}, 8'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule